// File: doc/BRIEF.md
# Wide Synchronous Link Flit Framer

This block frames packets onto a short, wide inter-switch link and recovers them at the far end. Both ends run on one shared clock. Each link cycle carries a 16-bit word and a 2-bit kind code. The code marks the word as idle filler, as the routing tag that opens a packet, as a body word, or as the closing word. One flit is one phit. Packet edges come only from the kind code: there are no in-band delimiters and no length fields.

The transmit half takes words from a local source. It sends the first word of each packet as a tag and the word flagged last as the closing word. In any cycle where it has nothing to send, or has run out of credit, it sends idle. The receive half decodes the kind code and keeps a packet-open state. Good words go into a small buffer and are handed to a local sink with start and end markers. A body or closing word that arrives with no open packet is dropped and reported. Flow control runs the other way on a separate 2-bit credit field. The field carries the number of flits the receiver has consumed in that cycle.

Top module: `flit_link`

## Requirements
- R1: After reset the transmit link carries idle (kind 00) with zero data. `src_ready` is 1, `snk_valid` is 0, `rx_credit` is 0 and `rx_frame_err` is 0.
- R2: The kind codes are 00 idle, 01 routing tag, 10 body and 11 closing word. The first accepted word of a packet is sent as 01. A later word with `src_last`=1 is sent as 11. Any other later word is sent as 10. A word accepted at a clock edge is on `tx_typ`/`tx_data` right after that edge.
- R3: In a cycle after an edge with no accepted word, the transmit link carries kind 00 with data 0.
- R4: The credit count starts at RX_DEPTH. Each sent flit takes one credit, and each cycle adds the value on `tx_credit_in`. At zero credits `src_ready` is 0 and no non-idle flit is sent.
- R5: A tag or body or closing flit accepted into the receive side shows at the sink right after the edge that samples it. The sink sees words in arrival order, with `snk_sop`=1 on the tag and `snk_eop`=1 on the closing word.
- R6: `rx_credit` gives one credit for each consumed flit, one cycle after the consuming edge. A flit is consumed when the sink pops it or when it is dropped as a framing error. A pop and a drop in the same cycle give 2.
- R7: A body (10) or closing (11) flit that arrives with no open packet is not stored. `rx_frame_err` pulses right after the edge that sampled it.
- R8: Idle flits on the receive side write nothing and return no credit.
- R9: Packets of random length and content, sent through the link under random sink backpressure, all arrive intact and in order.
- R10: The receive buffer is never written while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Transmitter holds credit and takes the word |
| src_data | input | DATA_W | Source word (first word of a packet is the routing tag) |
| src_last | input | 1 | Word closes its packet |
| tx_typ | output | 2 | Outgoing flit kind code |
| tx_data | output | DATA_W | Outgoing flit word |
| tx_credit_in | input | 2 | Credits returned by the far receiver this cycle |
| rx_typ | input | 2 | Incoming flit kind code |
| rx_data | input | DATA_W | Incoming flit word |
| rx_credit | output | 2 | Credits returned to the far transmitter |
| rx_frame_err | output | 1 | Pulse: orphan body or closing flit dropped |
| snk_valid | output | 1 | Received word available |
| snk_ready | input | 1 | Sink takes the word |
| snk_data | output | DATA_W | Received word |
| snk_sop | output | 1 | Word was a routing tag |
| snk_eop | output | 1 | Word closed its packet |

## Verification
Each result is due a fixed number of edges after its stimulus:

| Result | Due after |
|---|---|
| Flit on the link | the edge that accepted the word |
| Word at the sink | the next edge |
| Credit for a popped word | the edge after the pop |
| Credit and error pulse for a dropped flit | the edge that sampled it |

The bench changes inputs and samples outputs only on falling edges, and it checks each result at the first falling edge after the rising edge that produces it. The randomized run does not count cycles. It compares every pop against a queue of words built at the source, and it compares the total returned credit against the number of non-idle flits seen at the receiver.

// File: rtl/flit_link_pkg.sv
package flit_link_pkg;
  typedef enum logic [1:0] {
    FK_IDLE = 2'b00,
    FK_TAG  = 2'b01,
    FK_BODY = 2'b10,
    FK_END  = 2'b11
  } flit_kind_e;

  localparam int unsigned CREDIT_W = 2;
endpackage

// File: rtl/flit_credit_ctr.sv
module flit_credit_ctr #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spend,
  input  logic [1:0]    give,
  output logic          avail,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = spend | (give != 2'd0);
    cnt_n  = cnt_q - CW'(spend) + CW'(give);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(DEPTH);
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign avail = (cnt_q != '0);
  assign count = cnt_q;
endmodule

// File: rtl/flit_tx_framer.sv
module flit_tx_framer
  import flit_link_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_last,
  input  logic [1:0]        credit_in,
  output logic [1:0]        link_typ,
  output logic [DATA_W-1:0] link_data,
  output logic [CW-1:0]     credits
);
  logic              avail, accept, open_q, open_n;
  flit_kind_e        kind, typ_q, typ_n;
  logic [DATA_W-1:0] dat_q, dat_n;

  flit_credit_ctr #(.DEPTH(DEPTH), .CW(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .spend (accept),
    .give  (credit_in),
    .avail (avail),
    .count (credits)
  );

  always_comb begin
    accept = src_valid & avail;
    if (!open_q)       kind = FK_TAG;
    else if (src_last) kind = FK_END;
    else               kind = FK_BODY;
    open_n = open_q;
    typ_n  = FK_IDLE;
    dat_n  = '0;
    if (accept) begin
      open_n = (kind != FK_END);
      typ_n  = kind;
      dat_n  = src_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      typ_q  <= FK_IDLE;
      dat_q  <= '0;
    end else begin
      open_q <= open_n;
      typ_q  <= typ_n;
      dat_q  <= dat_n;
    end
  end

  assign src_ready = avail;
  assign link_typ  = typ_q;
  assign link_data = dat_q;
endmodule

// File: rtl/flit_rx_deframer.sv
module flit_rx_deframer
  import flit_link_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned EW     = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        link_typ,
  input  logic [DATA_W-1:0] link_data,
  output logic              wr,
  output logic [EW-1:0]     entry,
  output logic              drop,
  output logic              open,
  output logic              frame_err
);
  logic       open_q, open_n, err_q;
  logic       sop, eop;
  flit_kind_e kind;

  always_comb begin
    kind   = flit_kind_e'(link_typ);
    open_n = open_q;
    wr     = 1'b0;
    drop   = 1'b0;
    sop    = 1'b0;
    eop    = 1'b0;
    case (kind)
      FK_TAG: begin
        wr     = 1'b1;
        sop    = 1'b1;
        open_n = 1'b1;
      end
      FK_BODY: begin
        wr   = open_q;
        drop = !open_q;
      end
      FK_END: begin
        wr     = open_q;
        drop   = !open_q;
        eop    = open_q;
        open_n = 1'b0;
      end
      default: ;
    endcase
    entry = {sop, eop, link_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      open_q <= open_n;
      err_q  <= drop;
    end
  end

  assign open      = open_q;
  assign frame_err = err_q;
endmodule

// File: rtl/flit_rx_fifo.sv
module flit_rx_fifo #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_wr = wr & !full;
    do_rd = rd & !empty;
    wp_n  = do_wr ? bump(wp_q) : wp_q;
    rp_n  = do_rd ? bump(rp_q) : rp_q;
    cnt_n = cnt_q + CW'(do_wr) - CW'(do_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/flit_link.sv
module flit_link #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_last,
  output logic [1:0]        tx_typ,
  output logic [DATA_W-1:0] tx_data,
  input  logic [1:0]        tx_credit_in,
  input  logic [1:0]        rx_typ,
  input  logic [DATA_W-1:0] rx_data,
  output logic [1:0]        rx_credit,
  output logic              rx_frame_err,
  output logic              snk_valid,
  input  logic              snk_ready,
  output logic [DATA_W-1:0] snk_data,
  output logic              snk_sop,
  output logic              snk_eop
);
  localparam int unsigned EW = DATA_W + 2;
  localparam int unsigned CW = $clog2(RX_DEPTH + 1);

  logic [CW-1:0] tx_credits;
  logic          rx_wr, rx_drop, rx_open, rx_pop, rx_empty, rx_full;
  logic [EW-1:0] rx_entry, rx_head;
  logic [1:0]    cred_q, cred_n;

  flit_tx_framer #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH), .CW(CW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_data  (src_data),
    .src_last  (src_last),
    .credit_in (tx_credit_in),
    .link_typ  (tx_typ),
    .link_data (tx_data),
    .credits   (tx_credits)
  );

  flit_rx_deframer #(.DATA_W(DATA_W), .EW(EW)) u_dfr (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_typ  (rx_typ),
    .link_data (rx_data),
    .wr        (rx_wr),
    .entry     (rx_entry),
    .drop      (rx_drop),
    .open      (rx_open),
    .frame_err (rx_frame_err)
  );

  flit_rx_fifo #(.W(EW), .DEPTH(RX_DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (rx_wr),
    .wdata (rx_entry),
    .rd    (rx_pop),
    .rdata (rx_head),
    .empty (rx_empty),
    .full  (rx_full)
  );

  always_comb begin
    rx_pop = snk_ready & !rx_empty;
    cred_n = 2'(rx_pop) + 2'(rx_drop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cred_q <= 2'd0;
    else        cred_q <= cred_n;
  end

  assign rx_credit = cred_q;
  assign snk_valid = !rx_empty;
  assign snk_sop   = rx_head[EW-1];
  assign snk_eop   = rx_head[EW-2];
  assign snk_data  = rx_head[DATA_W-1:0];
endmodule

// File: rtl/flit_link_chk.sv
module flit_link_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned RX_DEPTH = 4,
  parameter int unsigned CW       = $clog2(RX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_valid,
  input logic              src_ready,
  input logic [DATA_W-1:0] src_data,
  input logic [1:0]        tx_typ,
  input logic [DATA_W-1:0] tx_data,
  input logic [CW-1:0]     tx_credits,
  input logic [1:0]        rx_typ,
  input logic [1:0]        rx_credit,
  input logic              rx_frame_err,
  input logic              rx_wr,
  input logic              rx_full,
  input logic              rx_open
);
  AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_valid && src_ready) |=> (tx_typ == 2'b00 && tx_data == '0)); // R3

  AST_FLIT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> (tx_typ != 2'b00 && tx_data == $past(src_data))); // R2

  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_credits) <= RX_DEPTH); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |-> !rx_full); // R10

  AST_ORPHAN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_typ[1] && !rx_open) |=> rx_frame_err); // R7

  AST_DROP_CREDITED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> (rx_credit != 2'd0)); // R6

  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_typ == 2'b00) |-> !rx_wr); // R8
endmodule

bind flit_link flit_link_chk #(.DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_valid    (src_valid),
  .src_ready    (src_ready),
  .src_data     (src_data),
  .tx_typ       (tx_typ),
  .tx_data      (tx_data),
  .tx_credits   (tx_credits),
  .rx_typ       (rx_typ),
  .rx_credit    (rx_credit),
  .rx_frame_err (rx_frame_err),
  .rx_wr        (rx_wr),
  .rx_full      (rx_full),
  .rx_open      (rx_open)
);

// File: tb/flit_link_bench.sv
`timescale 1ns/1ps
module flit_link_bench;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          src_valid, src_last, src_ready;
  logic [DW-1:0] src_data;
  logic [1:0]    tx_typ, tx_credit_in, rx_typ, rx_credit;
  logic [DW-1:0] tx_data, rx_data, snk_data;
  logic          rx_frame_err, snk_valid, snk_ready, snk_sop, snk_eop;

  logic          inj;
  logic [1:0]    inj_typ;
  logic [DW-1:0] inj_data;

  assign rx_typ       = inj ? inj_typ  : tx_typ;
  assign rx_data      = inj ? inj_data : tx_data;
  assign tx_credit_in = inj ? 2'd0     : rx_credit;

  flit_link #(.DATA_W(DW), .RX_DEPTH(DEPTH)) u_flit_link (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data), .src_last(src_last),
    .tx_typ(tx_typ), .tx_data(tx_data), .tx_credit_in(tx_credit_in),
    .rx_typ(rx_typ), .rx_data(rx_data), .rx_credit(rx_credit), .rx_frame_err(rx_frame_err),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
    .snk_sop(snk_sop), .snk_eop(snk_eop)
  );

  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int ready_pct = 0;
  bit mon_on = 1'b0;
  int cred_sum = 0;
  int rx_flits = 0;
  int tx_flits = 0;
  int cycles = 0;
  string mon_req = "R5";
  logic [DW+1:0] exp_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sink model, credit and flit counters, all on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      cred_sum += int'(rx_credit);
      if (rx_typ != 2'b00) rx_flits++;
      if (tx_typ != 2'b00) tx_flits++;
    end
    if (mon_on) snk_ready = (($urandom % 100) < ready_pct);
    else        snk_ready = 1'b0;
    if (snk_valid && snk_ready) begin
      if (exp_q.size() == 0) begin
        check(mon_req, {14'd0, snk_sop, snk_eop, snk_data}, 32'hDEAD);
      end else begin
        logic [DW+1:0] e;
        e = exp_q.pop_front();
        check(mon_req, {14'd0, snk_sop, snk_eop, snk_data}, {14'd0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic send_pkt(int len, logic [DW-1:0] base, int max_gap);
    for (int i = 0; i < len; i++) begin
      src_valid = 1'b1;
      src_data  = base + DW'(i * 7);
      src_last  = (i == len - 1);
      while (!src_ready) @(negedge clk);
      @(negedge clk);
      exp_q.push_back({i == 0, i == len - 1, base + DW'(i * 7)});
      src_valid = 1'b0;
      if (max_gap > 0) repeat ($urandom % (max_gap + 1)) @(negedge clk);
    end
    src_valid = 1'b0;
    src_last  = 1'b0;
  endtask

  task automatic drain(string req);
    int t = 0;
    while ((exp_q.size() != 0 || snk_valid) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    check(req, exp_q.size(), 0);
  endtask

  task automatic t_reset();
    check("R1 typ", tx_typ, 0);
    check("R1 data", tx_data, 0);
    check("R1 ready", src_ready, 1);
    check("R1 valid", snk_valid, 0);
    check("R1 credit", rx_credit, 0);
    check("R1 err", rx_frame_err, 0);
  endtask

  task automatic t_encode();
    logic [DW-1:0] w [3];
    w[0] = 16'hA5A1; w[1] = 16'h0B02; w[2] = 16'hC0E3;
    for (int i = 0; i < 3; i++) begin
      src_valid = 1'b1; src_data = w[i]; src_last = (i == 2);
      @(negedge clk);
      exp_q.push_back({i == 0, i == 2, w[i]});
      check("R2 kind", tx_typ, (i == 0) ? 1 : (i == 2) ? 3 : 2);
      check("R2 data", tx_data, w[i]);
      if (i == 1) begin
        check("R5 arrival", snk_valid, 1);
        check("R5 sop", snk_sop, 1);
        check("R5 data", snk_data, w[0]);
      end
    end
    src_valid = 1'b0; src_last = 1'b0;
    @(negedge clk);
    check("R3 idle kind", tx_typ, 0);
    check("R3 idle data", tx_data, 0);
    mon_req = "R5"; ready_pct = 100; mon_on = 1'b1;
    drain("R5 drained");
  endtask

  task automatic t_credit();
    int base_tx;
    ready_pct = 0;
    @(negedge clk);
    base_tx = tx_flits;
    fork
      send_pkt(6, 16'h3000, 0);
      begin
        repeat (10) @(negedge clk);
        check("R4 stall ready", src_ready, 0);
        check("R4 stall idle", tx_typ, 0);
        check("R4 flits at zero credit", tx_flits - base_tx, DEPTH);
        check("R10 full buffer held", snk_valid, 1);
        mon_req = "R10";
        ready_pct = 100;
      end
    join
    drain("R4 resumed");
    check("R4 credits back", src_ready, 1);
    check("R6 credit total", cred_sum, rx_flits);
  endtask

  task automatic inject(logic [1:0] k, logic [DW-1:0] d);
    inj_typ = k; inj_data = d;
    @(negedge clk);
    inj_typ = 2'b00; inj_data = '0;
  endtask

  task automatic t_frame();
    int c0;
    ready_pct = 100; mon_req = "R7";
    inj = 1'b1; inj_typ = 2'b00; inj_data = '0;
    @(negedge clk);
    inject(2'b10, 16'h1111);
    check("R7 err body", rx_frame_err, 1);
    check("R6 drop credit", rx_credit, 1);
    check("R7 not stored", snk_valid, 0);
    inject(2'b11, 16'h2222);
    check("R7 err end", rx_frame_err, 1);
    check("R7 end not stored", snk_valid, 0);
    @(negedge clk);
    c0 = cred_sum;
    inject(2'b00, 16'h3333);
    check("R8 idle credit", rx_credit, 0);
    check("R8 idle not stored", snk_valid, 0);
    check("R8 idle err", rx_frame_err, 0);
    @(negedge clk);
    check("R8 no credit sum", cred_sum, c0);
    exp_q.push_back({2'b10, 16'h4444});
    exp_q.push_back({2'b01, 16'h5555});
    inject(2'b01, 16'h4444);
    check("R7 tag ok", rx_frame_err, 0);
    inject(2'b11, 16'h5555);
    check("R7 end after tag ok", rx_frame_err, 0);
    drain("R7 framed pair");
    inj = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_random();
    ready_pct = 55; mon_req = "R9";
    for (int p = 0; p < 40; p++)
      send_pkt(2 + int'($urandom % 6), DW'($urandom), 2);
    drain("R9 all delivered");
    check("R9 credit total", cred_sum, rx_flits);
    check("R4 full credit at rest", src_ready, 1);
  endtask

  initial begin
    rst_n = 1'b0; src_valid = 1'b0; src_last = 1'b0; src_data = '0;
    inj = 1'b0; inj_typ = 2'b00; inj_data = '0; snk_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_encode();
    t_credit();
    t_frame();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule